// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. The program counter addresses a small instruction store. The fetched word is split into fixed fields. A main decoder turns the opcode into steering and write-enable controls, and a second decode stage picks the ALU function.

The core holds its own data store and a 32-entry register file. Two adders sit beside the ALU: one forms PC+4 and one forms the branch target. Both memories are plain internal arrays. A test environment preloads the instruction array by hierarchical assignment.

The results of each instruction are visible at the ports. The register write bus and the data-store write bus are brought out together with the current PC. The supported instructions are add, sub, and, or, slt, ori, lw, sw, beq and j. Any other opcode only advances the PC.

Top module: `sc_core`

## Requirements
- R1: R-type instructions use opcode 0. Fields are rs in [25:21], rt in [20:16] and rd in [15:11]. funct in [5:0] selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than giving 1 or 0. The result is written to rd.
- R2: A synchronous active-high reset sets the PC to 0, and the first instruction after reset is fetched from word 0.
- R3: Every instruction other than a taken beq or a j sets the next PC to PC+4. The PC is always word aligned.
- R4: ori (opcode 0x0D) writes rs OR the zero-extended imm16 (bits [15:0]) into rt.
- R5: lw (opcode 0x23) writes to rt the data-store word at address rs + sign-extended imm16. The word is indexed by address bits above bit 1.
- R6: sw (opcode 0x2B) writes the value of rt to the data store at rs + sign-extended imm16. That address and value appear on the store port, and no register is written.
- R7: beq (opcode 0x04) branches to PC+4 + (sign-extended imm16 << 2) when rs equals rt, and to PC+4 otherwise. It never writes a register or the data store.
- R8: j (opcode 0x02) sets the next PC to the upper 4 bits of PC+4 joined with target[25:0] << 2.
- R9: Register 0 always reads as zero. A write addressed to it has no effect.
- R10: An instruction whose destination is also a source reads the value held before its own write. The write becomes visible to the next instruction.
- R11: Any opcode outside the listed set writes neither a register nor the data store, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write enable of the current instruction |
| rf_waddr_o | output | 5 | Destination register of the current instruction |
| rf_wdata_o | output | 32 | Value to be written to the destination register |
| dm_we_o | output | 1 | Data-store write enable of the current instruction |
| dm_addr_o | output | 32 | Byte address computed by the ALU |
| dm_wdata_o | output | 32 | Store data (value of rt) |

## Verification
Within a single cycle, the register file serves reads from the current instruction while the same instruction's write waits for the clock edge. The bench provokes this overlap with back-to-back instructions such as add r11,r11,r11, whose source and destination coincide, and with a load whose result feeds the next add. A reference model in the bench executes the same program at instruction level for each sweep of operand pairs. The run is judged by comparing the write bus and the PC on every cycle: a doubling chain must show the old value read and the new one written.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int INSN_W = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [1:0] {
        ALUOP_ADD   = 2'b00,
        ALUOP_SUB   = 2'b01,
        ALUOP_FUNCT = 2'b10,
        ALUOP_OR    = 2'b11
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'd0,
        ALU_OR  = 3'd1,
        ALU_ADD = 3'd2,
        ALU_SUB = 3'd3,
        ALU_SLT = 3'd4
    } alu_fn_e;

    typedef struct packed {
        logic   reg_dst;
        logic   alu_src;
        logic   mem_to_reg;
        logic   reg_write;
        logic   mem_read;
        logic   mem_write;
        logic   branch;
        logic   jump;
        logic   imm_zext;
        aluop_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALUOP_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_op    = ALUOP_FUNCT;
            end
            OP_ORI: begin
                ctrl.alu_src   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.imm_zext  = 1'b1;
                ctrl.alu_op    = ALUOP_OR;
            end
            OP_LW: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            OP_SW: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OP_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALUOP_SUB;
            end
            OP_J: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (ctrl.alu_op)
            ALUOP_ADD: alu_fn = ALU_ADD;
            ALUOP_SUB: alu_fn = ALU_SUB;
            ALUOP_OR:  alu_fn = ALU_OR;
            default: begin
                case (funct)
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_fn_e      fn,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W     = 32,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        rf_we_o,
    output logic [4:0]  rf_waddr_o,
    output logic [31:0] rf_wdata_o,
    output logic        dm_we_o,
    output logic [31:0] dm_addr_o,
    output logic [31:0] dm_wdata_o
);

    typedef struct packed {
        logic [31:0] pc;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [INSN_W-1:0] imem [IMEM_WORDS];
    logic [31:0]       dmem [DMEM_WORDS];

    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem[i] = '0;
        end
    end

    logic [INSN_W-1:0] instr;
    logic [5:0]        opcode, funct;
    logic [REG_AW-1:0] rs, rt, rd;
    logic [15:0]       imm;
    ctrl_t             ctrl;
    alu_fn_e           alu_fn;
    logic [31:0]       rd1, rd2;
    logic [31:0]       imm_sext, imm_ext;
    logic [31:0]       alu_b, alu_y;
    logic              alu_zero;
    logic [31:0]       mem_rdata;
    logic [31:0]       pc_plus4, br_target, jmp_target;
    logic              unused_ok;

    assign instr  = imem[state_q.pc[IAW+1:2]];
    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign funct  = instr[5:0];
    assign imm    = instr[15:0];

    sc_ctrl u_ctrl (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    sc_regfile #(
        .W     (32),
        .DEPTH (32)
    ) u_rf (
        .clk (clk),
        .ra1 (rs),
        .ra2 (rt),
        .rd1 (rd1),
        .rd2 (rd2),
        .we  (ctrl.reg_write),
        .wa  (rf_waddr_o),
        .wd  (rf_wdata_o)
    );

    assign imm_sext = {{16{imm[15]}}, imm};
    assign imm_ext  = ctrl.imm_zext ? {16'b0, imm} : imm_sext;
    assign alu_b    = ctrl.alu_src ? imm_ext : rd2;

    sc_alu #(
        .W (32)
    ) u_alu (
        .a    (rd1),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign mem_rdata  = ctrl.mem_read ? dmem[alu_y[DAW+1:2]] : '0;
    assign pc_plus4   = state_q.pc + 32'd4;
    assign br_target  = pc_plus4 + {imm_sext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        state_d    = state_q;
        state_d.pc = pc_plus4;
        if (ctrl.branch && alu_zero) begin
            state_d.pc = br_target;
        end
        if (ctrl.jump) begin
            state_d.pc = jmp_target;
        end
        if (rst) begin
            state_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (ctrl.mem_write) begin
            dmem[alu_y[DAW+1:2]] <= rd2;
        end
    end

    assign pc_o       = state_q.pc;
    assign rf_we_o    = ctrl.reg_write;
    assign rf_waddr_o = ctrl.reg_dst ? rd : rt;
    assign rf_wdata_o = ctrl.mem_to_reg ? mem_rdata : alu_y;
    assign dm_we_o    = ctrl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rd2;

    assign unused_ok = ^ctrl.alu_op;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we
);

    logic [5:0]  op;
    logic [31:0] pc_inc;
    logic [31:0] jump_dest;
    logic        known_op;

    assign op        = instr[31:26];
    assign pc_inc    = pc + 32'd4;
    assign jump_dest = {pc_inc[31:28], instr[25:0], 2'b00};
    assign known_op  = (op == OP_RTYPE) || (op == OP_J) || (op == OP_BEQ) ||
                       (op == OP_ORI) || (op == OP_LW) || (op == OP_SW);

    AST_PC_RESET: assert property (@(posedge clk) rst |=> (pc == 32'd0)); // R2

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (pc[1:0] == 2'b00)); // R3

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
        ((op != OP_J) && (op != OP_BEQ)) |=> (pc == $past(pc) + 32'd4)); // R3

    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SW) |-> (!rf_we && dm_we)); // R6

    AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BEQ) |-> (!rf_we && !dm_we)); // R7

    AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
        (op == OP_J) |=> (pc == $past(jump_dest))); // R8

    AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst)
        !known_op |-> (!rf_we && !dm_we)); // R11

endmodule

bind sc_core sc_core_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .pc    (pc_o),
    .instr (instr),
    .rf_we (rf_we_o),
    .dm_we (dm_we_o)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    logic [31:0] prog  [64];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int s, input int t, input int d);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    function automatic string tag_of(input int idx, input logic [5:0] op);
        if (idx == 12 || idx == 13) return "R10";
        if (idx == 14 || idx == 15) return "R9";
        case (op)
            6'h00:   return "R1";
            6'h0D:   return "R4";
            6'h23:   return "R5";
            6'h2B:   return "R6";
            6'h04:   return "R7";
            6'h02:   return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic build(input logic [15:0] a, input logic [15:0] b);
        for (int i = 0; i < 64; i++) prog[i] = 32'hFC00_0000;
        prog[0]  = enc_i(6'h0D, 0, 1, a);
        prog[1]  = enc_i(6'h0D, 0, 2, b);
        prog[2]  = enc_r(6'h22, 0, 2, 3);
        prog[3]  = enc_r(6'h20, 1, 3, 4);
        prog[4]  = enc_r(6'h22, 1, 2, 5);
        prog[5]  = enc_r(6'h24, 1, 3, 6);
        prog[6]  = enc_r(6'h25, 1, 3, 7);
        prog[7]  = enc_r(6'h2A, 1, 3, 8);
        prog[8]  = enc_r(6'h2A, 3, 1, 9);
        prog[9]  = enc_i(6'h0D, 0, 12, 16'd16);
        prog[10] = enc_i(6'h2B, 12, 4, 16'hFFFC);
        prog[11] = enc_i(6'h23, 12, 10, 16'hFFFC);
        prog[12] = enc_r(6'h20, 10, 10, 11);
        prog[13] = enc_r(6'h20, 11, 11, 11);
        prog[14] = enc_r(6'h20, 1, 2, 0);
        prog[15] = enc_r(6'h25, 0, 0, 13);
        prog[16] = enc_i(6'h04, 1, 2, 16'd1);
        prog[17] = enc_i(6'h0D, 0, 14, 16'h0055);
        prog[18] = enc_i(6'h04, 1, 1, 16'd1);
        prog[19] = enc_i(6'h0D, 0, 15, 16'h00AA);
        prog[20] = {6'h3F, 5'd1, 5'd2, 16'h1234};
        prog[21] = {6'h02, 26'd23};
        prog[22] = enc_i(6'h0D, 0, 16, 16'd1);
        prog[23] = enc_i(6'h0D, 0, 17, 16'd7);
        prog[24] = enc_i(6'h04, 0, 0, 16'hFFFF);
    endtask

    task automatic step_check();
        logic [31:0] ins, pc4, se, ze, vs, vt, res, nxt, addr;
        logic [5:0]  op;
        bit          we, dwe;
        int          wa;
        string       tg;
        int          idx;
        idx = int'(m_pc[7:2]);
        ins = prog[idx];
        op  = ins[31:26];
        vs  = m_reg[ins[25:21]];
        vt  = m_reg[ins[20:16]];
        se  = {{16{ins[15]}}, ins[15:0]};
        ze  = {16'b0, ins[15:0]};
        pc4 = m_pc + 32'd4;
        nxt = pc4;
        we = 1'b0; dwe = 1'b0; wa = 0; res = '0; addr = vs + se;
        case (op)
            6'h00: begin
                we = 1'b1; wa = int'(ins[15:11]);
                case (ins[5:0])
                    6'h22:   res = vs - vt;
                    6'h24:   res = vs & vt;
                    6'h25:   res = vs | vt;
                    6'h2A:   res = ($signed(vs) < $signed(vt)) ? 32'd1 : 32'd0;
                    default: res = vs + vt;
                endcase
            end
            6'h0D: begin we = 1'b1; wa = int'(ins[20:16]); res = vs | ze; end
            6'h23: begin we = 1'b1; wa = int'(ins[20:16]); res = m_mem[addr[7:2]]; end
            6'h2B: dwe = 1'b1;
            6'h04: if (vs == vt) nxt = pc4 + {se[29:0], 2'b00};
            6'h02: nxt = {pc4[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        tg = tag_of(idx, op);
        chk(pc_o === m_pc, "R3", "pc", pc_o, m_pc);
        chk(rf_we_o === we, tg, "rf_we", 32'(rf_we_o), 32'(we));
        if (we) begin
            chk(rf_waddr_o === 5'(wa), tg, "rf_waddr", 32'(rf_waddr_o), 32'(wa));
            chk(rf_wdata_o === res, tg, "rf_wdata", rf_wdata_o, res);
        end
        chk(dm_we_o === dwe, tg, "dm_we", 32'(dm_we_o), 32'(dwe));
        if (dwe) begin
            chk(dm_addr_o === addr, "R6", "dm_addr", dm_addr_o, addr);
            chk(dm_wdata_o === vt, "R6", "dm_wdata", dm_wdata_o, vt);
            m_mem[addr[7:2]] = vt;
        end
        if (we && wa != 0) m_reg[wa] = res;
        m_pc = nxt;
    endtask

    task automatic run_case(input logic [15:0] a, input logic [15:0] b);
        rst = 1'b1;
        @(negedge clk);
        build(a, b);
        for (int i = 0; i < 64; i++) u_dut.imem[i] = prog[i];
        @(negedge clk);
        chk(pc_o === 32'd0, "R2", "pc in reset", pc_o, 32'd0);
        rst  = 1'b0;
        m_pc = 32'd0;
        #1;
        for (int c = 0; c < 40; c++) begin
            step_check();
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        logic [15:0] vals [6];
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        #1;
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                run_case(vals[i], vals[j]);
            end
        end
        rst = 1'b1;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule